// File: doc/BRIEF.md
# OTP Fuse Command Sequencer

This block sits between a simple register port and a behavioural model of a one-time-programmable fuse array. Software raises a power request and waits for the array to report that it is powered. It then issues commands through a single control word, which carries the fuse word index and the operation bits together.

Three operations exist:
- A shadow read copies a fuse word into a host-visible shadow register file.
- A program burns a target value, which the host loads into the write-data register beforehand. Fuse bits may only go from 0 to 1; a request that needs to clear a bit fails.
- A permanent lock sets bits in a separate lock-fuse area. Lower words use a two-bit lock field per word for redundancy. Upper words use a single lock bit per word.

Status shows busy, the running operation, program failure and power state. Banked registers hold a sticky error flag and a sticky disturbed flag for each word.

A command is refused when the array is unpowered or a command is already running. A refused command changes nothing, except that it raises the error flag of the word it named. Read and program latencies are fixed by parameter. A lock takes the program latency.

Top module: `otp_seq`

## Requirements
- R1: Bit 0 of the config register (offset 0x000) is the power request. Status bit 5 takes the request value exactly PWR_LAT clock edges after the request changes, in both directions. Before that it holds the old value.
- R2: A write to the control register (offset 0x004) with index in bits 6:0 starts a command. Bit 8 clear means shadow read, whatever bit 9 holds. Bit 8 set alone means program. Bits 8 and 9 both set mean permanent lock.
- R3: Status (offset 0x00C) bit 3 is high for exactly READ_LAT cycles after an accepted read, and for exactly PROG_LAT cycles after an accepted program or lock. While busy, bits 2:0 show 1 for read, 2 for program and 3 for lock. When idle they show 0.
- R4: A completed shadow read puts the fuse word at offset 0x200 + 4*index.
- R5: A program uses the write-data register (offset 0x008) as the target value. If no fuse bit that is already 1 would need to be cleared, the fuse word becomes the target and status bit 4 is cleared. Otherwise the fuse word is left unchanged and bit 4 is set. Bit 4 changes only when a program or lock completes.
- R6: Error flags are at offset 0x040 + 4*bank and disturbed flags at offset 0x060 + 4*bank. The bank is index >> 5 and the bit is index[4:0]. A failed program sets both flags of its word. A successful read or program clears both flags of its word.
- R7: A host write to a shadow offset stores the word directly, starts no command and does not raise busy.
- R8: A command issued while unpowered or busy is ignored. It starts nothing and changes no shadow word. It sets the error flag of the index it named.
- R9: Locking a lower word (index < UPPER_BASE) ORs binary 11 shifted left by (2*index mod 16) into lock word index/8. The lock words are 16 bits wide and read at offset 0x080 + 4*address.
- R10: Locking an upper word ORs 1 shifted left by (index mod 16) into lock word UPPER_BASE/8 + (index - UPPER_BASE)/16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 12 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The bench uses 96 words with the upper region starting at word 32. With that size the third flag bank and the last lock word (address 7) can be reached, and both lock mappings can be exercised at their edges. The read and program latencies keep their defaults of 4 and 16, so the busy windows can be counted cycle by cycle. The power latency is cut to 3 so the edge on which power rises and falls can be checked on both sides.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_READ = 3'd1,
    OP_PROG = 3'd2,
    OP_LOCK = 3'd3
  } op_e;

  localparam int unsigned OFS_CFG    = 'h000;
  localparam int unsigned OFS_CMD    = 'h004;
  localparam int unsigned OFS_WDAT   = 'h008;
  localparam int unsigned OFS_STAT   = 'h00C;
  localparam int unsigned OFS_ERR    = 'h040;
  localparam int unsigned OFS_DIST   = 'h060;
  localparam int unsigned OFS_LOCK   = 'h080;
  localparam int unsigned OFS_SHADOW = 'h200;
endpackage

// File: rtl/otp_pwr_ctrl.sv
module otp_pwr_ctrl #(
  parameter int unsigned PWR_LAT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pwr_on
);
  localparam int unsigned CW = $clog2(PWR_LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          on_d;

  always_comb begin
    cnt_d = '0;
    on_d  = pwr_on;
    if (req != pwr_on) begin
      if (cnt_q == CW'(PWR_LAT - 1)) on_d = req;
      else                           cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pwr_on <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pwr_on <= on_d;
    end
  end
endmodule

// File: rtl/otp_lock_map.sv
module otp_lock_map #(
  parameter int unsigned UPPER_BASE = 32,
  parameter int unsigned IDX_W      = 7,
  parameter int unsigned LA_W       = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [LA_W-1:0]  laddr,
  output logic [15:0]      lmask
);
  always_comb begin
    if (idx < IDX_W'(UPPER_BASE)) begin
      // two redundant lock bits per lower word, eight words per lock word
      laddr = LA_W'(idx >> 3);
      lmask = 16'h0003 << {idx[2:0], 1'b0};
    end else begin
      // one lock bit per upper word, sixteen words per lock word
      laddr = LA_W'(UPPER_BASE / 8) + LA_W'((idx - IDX_W'(UPPER_BASE)) >> 4);
      lmask = 16'h0001 << idx[3:0];
    end
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int unsigned NWORDS = 96,
  parameter int unsigned NLOCKW = 8,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned LA_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [31:0]          rd_word,
  input  logic                 prog_en,
  input  logic [IDX_W-1:0]     prog_idx,
  input  logic [31:0]          prog_word,
  input  logic                 lock_en,
  input  logic [LA_W-1:0]      lock_addr,
  input  logic [15:0]          lock_mask,
  output logic [NLOCKW*16-1:0] lock_words
);
  logic [31:0] fuse_q [NWORDS];
  logic [15:0] lock_q [NLOCKW];

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   fuse_q[w] <= '0;
      else if (prog_en && prog_idx == IDX_W'(w))    fuse_q[w] <= fuse_q[w] | prog_word;
    end
  end

  for (genvar l = 0; l < NLOCKW; l++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   lock_q[l] <= '0;
      else if (lock_en && lock_addr == LA_W'(l))    lock_q[l] <= lock_q[l] | lock_mask;
    end
    assign lock_words[l*16 +: 16] = lock_q[l];
  end

  assign rd_word = fuse_q[rd_idx];
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_seq_pkg::*;
#(
  parameter int unsigned NWORDS     = 96,
  parameter int unsigned UPPER_BASE = 32,
  parameter int unsigned READ_LAT   = 4,
  parameter int unsigned PROG_LAT   = 16,
  parameter int unsigned PWR_LAT    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int unsigned IDX_W  = $clog2(NWORDS);
  localparam int unsigned NBANK  = (NWORDS + 31) / 32;
  localparam int unsigned NLOCKW = UPPER_BASE / 8 + (NWORDS - UPPER_BASE + 15) / 16;
  localparam int unsigned LA_W   = (NLOCKW > 1) ? $clog2(NLOCKW) : 1;
  localparam int unsigned MAXLAT = (PROG_LAT > READ_LAT) ? PROG_LAT : READ_LAT;
  localparam int unsigned CW     = $clog2(MAXLAT + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  // register state
  logic                 cfg_req_q;
  logic [31:0]          wdata_q;
  logic                 busy_q, busy_d;
  op_e                  mode_q, mode_d, cmd_op;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [IDX_W-1:0]     idx_q, idx_d, cmd_idx;
  logic [31:0]          pdata_q, pdata_d;
  logic                 pfail_q, pfail_d;
  logic [NBANK*32-1:0]  err_q, err_d, dist_q, dist_d;
  logic [31:0]          shadow_q [NWORDS];

  logic                 pwr_on, wr_cfg, wr_cmd, wr_wdat, cmd_in_range;
  logic                 accept, reject, done, prog_fail, prog_en, lock_en, rd_done;
  logic [31:0]          fuse_rd;
  logic [LA_W-1:0]      laddr;
  logic [15:0]          lmask;
  logic [NLOCKW*16-1:0] lock_words;

  assign wr_cfg  = reg_wr && reg_addr == 12'(OFS_CFG);
  assign wr_cmd  = reg_wr && reg_addr == 12'(OFS_CMD);
  assign wr_wdat = reg_wr && reg_addr == 12'(OFS_WDAT);

  assign cmd_idx      = reg_wdata[IDX_W-1:0];
  assign cmd_in_range = {1'b0, cmd_idx} < (IDX_W + 1)'(NWORDS);
  assign cmd_op       = !reg_wdata[8] ? OP_READ : (reg_wdata[9] ? OP_LOCK : OP_PROG);
  assign accept       = wr_cmd && cmd_in_range && pwr_on && !busy_q;
  assign reject       = wr_cmd && cmd_in_range && !(pwr_on && !busy_q);
  assign done         = busy_q && cnt_q == '0;
  assign prog_fail    = |(fuse_rd & ~pdata_q);
  assign prog_en      = done && mode_q == OP_PROG && !prog_fail;
  assign lock_en      = done && mode_q == OP_LOCK;
  assign rd_done      = done && mode_q == OP_READ;

  otp_pwr_ctrl #(.PWR_LAT(PWR_LAT)) u_pwr (
    .clk(clk), .rst_n(srst_n), .req(cfg_req_q), .pwr_on(pwr_on)
  );

  otp_lock_map #(.UPPER_BASE(UPPER_BASE), .IDX_W(IDX_W), .LA_W(LA_W)) u_map (
    .idx(idx_q), .laddr(laddr), .lmask(lmask)
  );

  otp_fuse_array #(.NWORDS(NWORDS), .NLOCKW(NLOCKW), .IDX_W(IDX_W), .LA_W(LA_W)) u_fuse (
    .clk(clk), .rst_n(srst_n), .rd_idx(idx_q), .rd_word(fuse_rd),
    .prog_en(prog_en), .prog_idx(idx_q), .prog_word(pdata_q),
    .lock_en(lock_en), .lock_addr(laddr), .lock_mask(lmask), .lock_words(lock_words)
  );

  // next state of the command sequencer and flag banks
  always_comb begin
    busy_d  = busy_q;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    pdata_d = pdata_q;
    pfail_d = pfail_q;
    err_d   = err_q;
    dist_d  = dist_q;
    if (done) begin
      busy_d = 1'b0;
      mode_d = OP_IDLE;
      if (mode_q == OP_LOCK) pfail_d = 1'b0;
      if (mode_q == OP_PROG) pfail_d = prog_fail;
      if (mode_q == OP_READ || (mode_q == OP_PROG && !prog_fail)) begin
        err_d[idx_q]  = 1'b0;
        dist_d[idx_q] = 1'b0;
      end else if (mode_q == OP_PROG) begin
        err_d[idx_q]  = 1'b1;
        dist_d[idx_q] = 1'b1;
      end
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
    if (accept) begin
      busy_d  = 1'b1;
      mode_d  = cmd_op;
      idx_d   = cmd_idx;
      pdata_d = wdata_q;
      cnt_d   = (cmd_op == OP_READ) ? CW'(READ_LAT - 1) : CW'(PROG_LAT - 1);
    end
    if (reject) err_d[cmd_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q  <= 1'b0;
      mode_q  <= OP_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      pdata_q <= '0;
      pfail_q <= 1'b0;
      err_q   <= '0;
      dist_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      pdata_q <= pdata_d;
      pfail_q <= pfail_d;
      err_q   <= err_d;
      dist_q  <= dist_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      cfg_req_q <= 1'b0;
      wdata_q   <= '0;
    end else begin
      if (wr_cfg)  cfg_req_q <= reg_wdata[0];
      if (wr_wdat) wdata_q   <= reg_wdata;
    end
  end

  // shadow file: a completing read wins over a host write in the same cycle
  for (genvar w = 0; w < NWORDS; w++) begin : g_shadow
    logic sh_host, sh_fill;
    assign sh_host = reg_wr && reg_addr == 12'(OFS_SHADOW + 4 * w);
    assign sh_fill = rd_done && idx_q == IDX_W'(w);
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)      shadow_q[w] <= '0;
      else if (sh_fill) shadow_q[w] <= fuse_rd;
      else if (sh_host) shadow_q[w] <= reg_wdata;
    end
  end

  // read-back decode
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 12'(OFS_CFG))  reg_rdata = {31'b0, cfg_req_q};
    if (reg_addr == 12'(OFS_WDAT)) reg_rdata = wdata_q;
    if (reg_addr == 12'(OFS_STAT)) reg_rdata = {26'b0, pwr_on, pfail_q, busy_q, mode_q};
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr == 12'(OFS_ERR + 4 * b))  reg_rdata = err_q[b*32 +: 32];
      if (reg_addr == 12'(OFS_DIST + 4 * b)) reg_rdata = dist_q[b*32 +: 32];
    end
    for (int l = 0; l < NLOCKW; l++)
      if (reg_addr == 12'(OFS_LOCK + 4 * l)) reg_rdata = {16'b0, lock_words[l*16 +: 16]};
    for (int w = 0; w < NWORDS; w++)
      if (reg_addr == 12'(OFS_SHADOW + 4 * w)) reg_rdata = shadow_q[w];
  end
endmodule

// File: rtl/otp_seq_chk.sv
module otp_seq_chk #(
  parameter int unsigned PROG_LAT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_req,
  input logic       pwr_on,
  input logic       busy,
  input logic [2:0] mode,
  input logic       progfail
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 0;
    end else begin
      run_q <= busy ? run_q + 1 : 0;
      // R3: no busy window outlasts the longest command latency
      if (busy) a_r3_busy_bound: assert (run_q < PROG_LAT);
    end
  end

  a_r1_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> $past(pwr_req));

  a_r1_fall_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_on) |-> !$past(pwr_req));

  a_r8_start_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_on));

  a_r3_mode_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode != 3'd0));

  a_r3_idle_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mode == 3'd0));

  a_r5_fail_from_prog: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(progfail) |-> $past(busy && mode == 3'd2));
endmodule

bind otp_seq otp_seq_chk #(.PROG_LAT(PROG_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_req(cfg_req_q), .pwr_on(pwr_on),
  .busy(busy_q), .mode(mode_q), .progfail(pfail_q)
);

// File: tb/otp_seq_bench.sv
`timescale 1ns/1ps
module otp_seq_bench;
  localparam logic [11:0] A_CFG  = 12'h000;
  localparam logic [11:0] A_CMD  = 12'h004;
  localparam logic [11:0] A_WDAT = 12'h008;
  localparam logic [11:0] A_STAT = 12'h00C;
  localparam logic [11:0] A_ERR  = 12'h040;
  localparam logic [11:0] A_DIST = 12'h060;
  localparam logic [11:0] A_LOCK = 12'h080;
  localparam logic [11:0] A_SH   = 12'h200;

  logic        clk, rst_n, reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  int          n_chk, n_bad;

  otp_seq #(.NWORDS(96), .UPPER_BASE(32), .READ_LAT(4), .PROG_LAT(16), .PWR_LAT(3)) u_otp_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // scoreboard queues, filled by the driver and drained by the monitor
  logic [31:0] q_exp  [$];
  logic [11:0] q_addr [$];
  string       q_tag  [$];
  logic [31:0] m_exp;
  logic [11:0] m_addr;
  string       m_tag;

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      m_exp  = q_exp.pop_front();
      m_addr = q_addr.pop_front();
      m_tag  = q_tag.pop_front();
      n_chk++;
      if (reg_rdata !== m_exp) begin
        n_bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", m_tag, m_addr, reg_rdata, m_exp);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    q_exp.push_back(e); q_addr.push_back(a); q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  // called right after a control write: counts busy cycles, records the mode
  task automatic busy_run(input int exp_len, input int exp_mode, input string tag);
    int len = 0;
    int mode;
    reg_addr = A_STAT;
    @(negedge clk);
    mode = int'(reg_rdata[2:0]);
    while (reg_rdata[3] && len < 1000) begin
      len++;
      @(negedge clk);
    end
    chk(len, exp_len, tag);
    chk(mode, exp_mode, tag);
  endtask

  // called right after a config write: checks the edge where power flips
  task automatic pwr_edge(input int new_val, input string tag);
    int s3, s4;
    reg_addr = A_STAT;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); s3 = int'(reg_rdata[5]);
    @(negedge clk); s4 = int'(reg_rdata[5]);
    chk(s3, 1 - new_val, tag);
    chk(s4, new_val, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // reset state
    expect_rd(A_CFG, 32'h0, "R1 reset config");
    expect_rd(A_STAT, 32'h0, "R3 reset status");
    expect_rd(A_SH, 32'h0, "R4 reset shadow");
    expect_rd(A_WDAT, 32'h0, "R5 reset wdata");

    // commands while unpowered are refused and flagged
    wr(A_CMD, 32'h0000_0003);
    expect_rd(A_STAT, 32'h0, "R8 no start unpowered");
    expect_rd(A_ERR, 32'h0000_0008, "R8 error flag word 3");
    wr(A_CMD, 32'h0000_0040);
    expect_rd(A_ERR + 12'h8, 32'h0000_0001, "R6 bank 2 bit 0");

    // power up
    wr(A_CFG, 32'h1);
    pwr_edge(1, "R1 power up delay");
    expect_rd(A_STAT, 32'h20, "R1 powered status");

    // program then read word 3
    wr(A_WDAT, 32'h0000_00F0);
    wr(A_CMD, 32'h0000_0103);
    busy_run(16, 2, "R3 program busy");
    expect_rd(A_STAT, 32'h20, "R5 program ok");
    expect_rd(A_ERR, 32'h0, "R6 flag cleared by program");
    wr(A_CMD, 32'h0000_0003);
    busy_run(4, 1, "R3 read busy");
    expect_rd(A_SH + 12'd12, 32'h0000_00F0, "R4 shadow word 3");
    wr(A_CMD, 32'h0000_0203);
    busy_run(4, 1, "R2 bit9 alone reads");

    // program that would clear bits fails
    wr(A_WDAT, 32'h0000_000F);
    wr(A_CMD, 32'h0000_0103);
    busy_run(16, 2, "R5 failing program busy");
    expect_rd(A_STAT, 32'h30, "R5 progfail set");
    expect_rd(A_ERR, 32'h0000_0008, "R6 error on fail");
    expect_rd(A_DIST, 32'h0000_0008, "R6 disturbed on fail");
    wr(A_CMD, 32'h0000_0003);
    busy_run(4, 1, "R3 read busy");
    expect_rd(A_SH + 12'd12, 32'h0000_00F0, "R5 fuse unchanged");
    expect_rd(A_STAT, 32'h30, "R5 progfail kept by read");
    expect_rd(A_ERR, 32'h0, "R6 error cleared by read");
    expect_rd(A_DIST, 32'h0, "R6 disturbed cleared by read");
    wr(A_WDAT, 32'h0000_00FF);
    wr(A_CMD, 32'h0000_0103);
    busy_run(16, 2, "R5 program adds bits");
    expect_rd(A_STAT, 32'h20, "R5 progfail cleared");
    wr(A_CMD, 32'h0000_0003);
    busy_run(4, 1, "R3 read busy");
    expect_rd(A_SH + 12'd12, 32'h0000_00FF, "R5 fuse grown");

    // command while busy is refused
    wr(A_WDAT, 32'hA5A5_0000);
    wr(A_CMD, 32'h0000_0128);
    wr(A_CMD, 32'h0000_0029);
    repeat (20) @(posedge clk);
    expect_rd(A_ERR + 12'h4, 32'h0000_0200, "R8 error word 41");
    expect_rd(A_DIST + 12'h4, 32'h0, "R8 no disturbed word 41");
    expect_rd(A_SH + 12'd164, 32'h0, "R8 shadow 41 untouched");
    wr(A_CMD, 32'h0000_0028);
    busy_run(4, 1, "R3 read busy");
    expect_rd(A_SH + 12'd160, 32'hA5A5_0000, "R4 shadow word 40");

    // host writes a shadow word directly
    wr(A_SH + 12'd280, 32'h1234_5678);
    expect_rd(A_SH + 12'd280, 32'h1234_5678, "R7 host shadow write");
    expect_rd(A_STAT, 32'h20, "R7 no busy");
    wr(A_CMD, 32'h0000_0046);
    busy_run(4, 1, "R3 read busy");
    expect_rd(A_SH + 12'd280, 32'h0, "R4 read overwrites shadow");

    // permanent locks
    wr(A_CMD, 32'h0000_0305);
    busy_run(16, 3, "R9 lock busy");
    expect_rd(A_LOCK, 32'h0000_0C00, "R9 lock word 5");
    wr(A_CMD, 32'h0000_0307);
    busy_run(16, 3, "R9 lock busy");
    expect_rd(A_LOCK, 32'h0000_CC00, "R9 lock word 7");
    wr(A_CMD, 32'h0000_030A);
    busy_run(16, 3, "R9 lock busy");
    expect_rd(A_LOCK + 12'h4, 32'h0000_0030, "R9 lock word 10");
    wr(A_CMD, 32'h0000_0328);
    busy_run(16, 3, "R10 lock busy");
    expect_rd(A_LOCK + 12'h10, 32'h0000_0100, "R10 lock word 40");
    wr(A_CMD, 32'h0000_035F);
    busy_run(16, 3, "R10 lock busy");
    expect_rd(A_LOCK + 12'h1C, 32'h0000_8000, "R10 lock word 95");
    expect_rd(A_STAT, 32'h20, "R5 lock leaves no fail");

    // power down, then a refused command
    wr(A_CFG, 32'h0);
    pwr_edge(0, "R1 power down delay");
    wr(A_CMD, 32'h0000_0002);
    expect_rd(A_STAT, 32'h0, "R8 no start after power down");
    expect_rd(A_ERR, 32'h0000_0004, "R8 error word 2");

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule